// File: doc/BRIEF.md
# Compressed Line Coherency Controller

This block keeps track, for every scanline of the screen, of whether a compressed copy of that line may be used for refresh. Two on-chip bits per line record whether the compressed copy is good (valid) and whether the host has written to the line since it was last compressed (dirty). For each line fetch the display pipeline issues, the block answers one cycle later with the source to read: the compressed buffer or the uncompressed frame buffer.

Host writes are snooped by address and mark the touched line dirty. The compressor reports the outcome of each line it worked on. A success makes the line valid, clears its dirty bit and raises a write-back request. A failure makes the line not valid and requests nothing. A frame pacer counts static frames. While its count is non-zero, dirty bits are ignored, so the image update rate can be set lower than the refresh rate. A 64 by 32-bit staging buffer holds freshly compressed words until the write-back engine reads them out. A global invalidate drops every valid bit, for example after a display mode change.

Top module: `line_coherency_ctrl`

## Requirements
- R1: After reset every line is neither dirty nor valid, the frame pacer count is 0, `fetch_vld` and `wb_req` are low, and every fetch selects the frame buffer.
- R2: `fetch_vld` is high in exactly the cycle after a cycle with `fetch_req` high. In that cycle `fetch_cmp` gives the source, 1 meaning the compressed buffer and 0 the frame buffer. The answer is based on the line state as it stood in the request cycle.
- R3: A line that is not valid is fetched from the frame buffer. A line that is valid and not dirty is fetched from the compressed buffer.
- R4: A host write at any address sets the dirty bit of line `host_wr_addr >> LINE_OFS_W`. On a frame whose pacer count is 0, a line that is dirty and valid is fetched from the frame buffer.
- R5: A compression report with `cmp_ok`=1 makes `cmp_line` valid and clears its dirty bit. In the next cycle `wb_req` is high for one cycle with `wb_line` equal to that line.
- R6: A compression report with `cmp_ok`=0 clears the valid bit of `cmp_line`, leaves its dirty bit unchanged and raises no `wb_req`.
- R7: When a host write hits the same line as a successful compression report in the same cycle, the line ends up dirty and not valid, and no `wb_req` follows.
- R8: On each `frame_start` the pacer count loads `static_reload` if it was 0, and otherwise decreases by 1. Dirty bits take part in the source choice only while the count is 0, so a reload value of 0 samples them on every frame.
- R9: While the pacer count is non-zero, a valid line is fetched from the compressed buffer even if it is dirty.
- R10: `inval_all` clears every valid bit. This includes a line reported as successfully compressed in the same cycle, and that report then raises no `wb_req`.
- R11: The staging buffer stores `stg_wr_data` at `stg_wr_idx` when `stg_wr_en` is high. `stg_rd_data` returns the word at `stg_rd_idx` one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse at the start of each displayed frame |
| static_reload | input | CNT_W | Number of static frames between dirty-sampling frames |
| inval_all | input | 1 | Clear every valid bit |
| host_wr_en | input | 1 | Host write snoop strobe |
| host_wr_addr | input | ADDR_W | Frame buffer byte address of the host write |
| fetch_req | input | 1 | Line fetch lookup request |
| fetch_line | input | LINE_W | Line being fetched |
| fetch_vld | output | 1 | Lookup answer present |
| fetch_cmp | output | 1 | 1: read compressed buffer, 0: read frame buffer |
| cmp_done | input | 1 | Compressor result strobe |
| cmp_ok | input | 1 | Compression succeeded |
| cmp_line | input | LINE_W | Line the result refers to |
| wb_req | output | 1 | Write-back request pulse |
| wb_line | output | LINE_W | Line to write back |
| stg_wr_en | input | 1 | Staging buffer write enable |
| stg_wr_idx | input | STG_IDX_W | Staging buffer write index |
| stg_wr_data | input | STG_W | Staging buffer write data |
| stg_rd_idx | input | STG_IDX_W | Staging buffer read index |
| stg_rd_data | output | STG_W | Staging buffer read data |

## Verification
The hardest situation to reach is a line that is both dirty and valid while the pacer sits at a non-zero count. Here the choice differs from a plain valid check. Reaching it needs a successful compression, then a host write, then frame pulses with a non-zero reload. The bench builds that state on a small 16-line configuration, steps the pacer through a full reload cycle, and sweeps a fetch of every line after each step. The same-cycle collisions (host write against a success, invalidate against a success) are driven deliberately in single cycles, and the sweep that follows shows which bits survived.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic {
        SRC_FRAME = 1'b0,
        SRC_COMP  = 1'b1
    } fetch_src_e;

    // Compressed copy is usable when valid, unless dirty matters this frame and is set.
    function automatic fetch_src_e pick_source(input logic valid, input logic dirty,
                                               input logic sample);
        return (valid && !(dirty && sample)) ? SRC_COMP : SRC_FRAME;
    endfunction

endpackage

// File: rtl/lcc_frame_pacer.sv
module lcc_frame_pacer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] reload,
    output logic             sample
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pacer_t;

    pacer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample = (st_q.cnt == '0);

endmodule

// File: rtl/lcc_line_state.sv
module lcc_line_state
    import lcc_pkg::*;
#(
    parameter int NUM_LINES = 1024,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              host_hit,
    input  logic [LINE_W-1:0] host_line,
    input  logic              cmp_done,
    input  logic              cmp_ok,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic              inval_all,
    input  logic              fetch_req,
    input  logic [LINE_W-1:0] fetch_line,
    output logic              fetch_vld,
    output logic              fetch_cmp,
    output logic              wb_req,
    output logic [LINE_W-1:0] wb_line
);

    typedef struct packed {
        logic [NUM_LINES-1:0] dirty;
        logic [NUM_LINES-1:0] valid;
        logic                 fetch_vld;
        logic                 fetch_cmp;
        logic                 wb_req;
        logic [LINE_W-1:0]    wb_line;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     collide;

    assign collide = host_hit && cmp_done && (host_line == cmp_line);

    always_comb begin
        st_d = st_q;

        // Lookup uses the state as it stands before this cycle's updates.
        st_d.fetch_vld = fetch_req;
        st_d.fetch_cmp = fetch_req &&
            (pick_source(st_q.valid[fetch_line], st_q.dirty[fetch_line], sample) == SRC_COMP);

        st_d.wb_req = 1'b0;
        if (cmp_done) begin
            if (cmp_ok && !collide) begin
                st_d.valid[cmp_line] = 1'b1;
                st_d.dirty[cmp_line] = 1'b0;
                st_d.wb_req          = !inval_all;
                st_d.wb_line         = cmp_line;
            end else begin
                st_d.valid[cmp_line] = 1'b0;
            end
        end

        // Applied after the compressor update so a colliding write keeps dirty set.
        if (host_hit) begin
            st_d.dirty[host_line] = 1'b1;
        end

        if (inval_all) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_vld = st_q.fetch_vld;
    assign fetch_cmp = st_q.fetch_cmp;
    assign wb_req    = st_q.wb_req;
    assign wb_line   = st_q.wb_line;

endmodule

// File: rtl/lcc_stage_buf.sv
module lcc_stage_buf #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    typedef struct packed {
        logic [WIDTH-1:0] rd;
    } stage_rd_t;

    logic [WIDTH-1:0] mem_q [DEPTH];
    stage_rd_t        st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = mem_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/line_coherency_ctrl.sv
module line_coherency_ctrl #(
    parameter int  NUM_LINES  = 1024,
    parameter int  LINE_OFS_W = 12,
    parameter int  CNT_W      = 4,
    parameter int  STG_DEPTH  = 64,
    parameter int  STG_W      = 32,
    localparam int LINE_W     = $clog2(NUM_LINES),
    localparam int ADDR_W     = LINE_W + LINE_OFS_W,
    localparam int STG_IDX_W  = $clog2(STG_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [CNT_W-1:0]     static_reload,
    input  logic                 inval_all,
    input  logic                 host_wr_en,
    input  logic [ADDR_W-1:0]    host_wr_addr,
    input  logic                 fetch_req,
    input  logic [LINE_W-1:0]    fetch_line,
    output logic                 fetch_vld,
    output logic                 fetch_cmp,
    input  logic                 cmp_done,
    input  logic                 cmp_ok,
    input  logic [LINE_W-1:0]    cmp_line,
    output logic                 wb_req,
    output logic [LINE_W-1:0]    wb_line,
    input  logic                 stg_wr_en,
    input  logic [STG_IDX_W-1:0] stg_wr_idx,
    input  logic [STG_W-1:0]     stg_wr_data,
    input  logic [STG_IDX_W-1:0] stg_rd_idx,
    output logic [STG_W-1:0]     stg_rd_data
);

    logic              sample;
    logic [LINE_W-1:0] host_line;
    logic              unused_ofs;

    assign host_line  = host_wr_addr[ADDR_W-1:LINE_OFS_W];
    assign unused_ofs = ^host_wr_addr[LINE_OFS_W-1:0];

    lcc_frame_pacer #(.CNT_W(CNT_W)) i_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .reload      (static_reload),
        .sample      (sample)
    );

    lcc_line_state #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .host_hit   (host_wr_en),
        .host_line  (host_line),
        .cmp_done   (cmp_done),
        .cmp_ok     (cmp_ok),
        .cmp_line   (cmp_line),
        .inval_all  (inval_all),
        .fetch_req  (fetch_req),
        .fetch_line (fetch_line),
        .fetch_vld  (fetch_vld),
        .fetch_cmp  (fetch_cmp),
        .wb_req     (wb_req),
        .wb_line    (wb_line)
    );

    lcc_stage_buf #(.DEPTH(STG_DEPTH), .WIDTH(STG_W), .IDX_W(STG_IDX_W)) i_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stg_wr_en),
        .wr_idx  (stg_wr_idx),
        .wr_data (stg_wr_data),
        .rd_idx  (stg_rd_idx),
        .rd_data (stg_rd_data)
    );

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
    parameter int LINE_W     = 10,
    parameter int LINE_OFS_W = 12,
    parameter int ADDR_W     = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inval_all,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_wr_addr,
    input logic              fetch_req,
    input logic              fetch_vld,
    input logic              fetch_cmp,
    input logic              cmp_done,
    input logic              cmp_ok,
    input logic [LINE_W-1:0] cmp_line,
    input logic              wb_req,
    input logic [LINE_W-1:0] wb_line
);

    logic collide;
    assign collide = host_wr_en && cmp_done &&
                     (host_wr_addr[ADDR_W-1:LINE_OFS_W] == cmp_line);

    AST_FETCH_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_vld); // R2
    AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> (!fetch_vld && !fetch_cmp)); // R2
    AST_WB_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && cmp_ok && !collide && !inval_all) |=> (wb_req && wb_line == $past(cmp_line))); // R5
    AST_WB_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> $past(cmp_done && cmp_ok)); // R5
    AST_NO_WB_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && !cmp_ok) |=> !wb_req); // R6
    AST_NO_WB_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> !wb_req); // R7
    AST_NO_WB_ON_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !wb_req); // R10

endmodule

bind line_coherency_ctrl lcc_checker #(
    .LINE_W(LINE_W), .LINE_OFS_W(LINE_OFS_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inval_all    (inval_all),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .fetch_req    (fetch_req),
    .fetch_vld    (fetch_vld),
    .fetch_cmp    (fetch_cmp),
    .cmp_done     (cmp_done),
    .cmp_ok       (cmp_ok),
    .cmp_line     (cmp_line),
    .wb_req       (wb_req),
    .wb_line      (wb_line)
);

// File: tb/test_line_coherency_ctrl.sv
module test_line_coherency_ctrl;

    localparam int NL  = 16;
    localparam int OFW = 3;
    localparam int CW  = 3;
    localparam int LW  = 4;
    localparam int AW  = LW + OFW;
    localparam int SD  = 64;
    localparam int SW  = 32;
    localparam int SIW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [CW-1:0] static_reload = '0;
    logic          inval_all = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic          fetch_req = 1'b0;
    logic [LW-1:0] fetch_line = '0;
    logic          fetch_vld, fetch_cmp;
    logic          cmp_done = 1'b0, cmp_ok = 1'b0;
    logic [LW-1:0] cmp_line = '0;
    logic          wb_req;
    logic [LW-1:0] wb_line;
    logic          stg_wr_en = 1'b0;
    logic [SIW-1:0] stg_wr_idx = '0, stg_rd_idx = '0;
    logic [SW-1:0] stg_wr_data = '0;
    logic [SW-1:0] stg_rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit md [NL];
    bit mv [NL];
    int mcnt = 0;

    always #10 clk = ~clk;

    line_coherency_ctrl #(
        .NUM_LINES(NL), .LINE_OFS_W(OFW), .CNT_W(CW), .STG_DEPTH(SD), .STG_W(SW)
    ) i_line_coherency_ctrl (.*);

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_src(input int l);
        return mv[l] && !(md[l] && mcnt == 0);
    endfunction

    task automatic fetch_chk(input int l, input string req);
        bit e;
        e = exp_src(l);
        fetch_req = 1'b1;
        fetch_line = LW'(l);
        tick();
        fetch_req = 1'b0;
        check(fetch_vld == 1'b1, req, longint'(fetch_vld), 1);
        check(fetch_cmp == e, req, longint'(fetch_cmp), longint'(e));
    endtask

    task automatic sweep(input string req);
        for (int l = 0; l < NL; l++) fetch_chk(l, req);
    endtask

    task automatic hwrite(input int l, input int ofs);
        host_wr_en = 1'b1;
        host_wr_addr = AW'((l << OFW) | ofs);
        tick();
        host_wr_en = 1'b0;
        md[l] = 1'b1;
    endtask

    task automatic compress(input int l, input bit ok, input bit hw, input int hl,
                            input bit inv, input string req);
        bit hit, ewb;
        hit = hw && (hl == l);
        ewb = ok && !hit && !inv;
        cmp_done = 1'b1; cmp_ok = ok; cmp_line = LW'(l);
        host_wr_en = hw; host_wr_addr = AW'(hl << OFW);
        inval_all = inv;
        tick();
        cmp_done = 1'b0; cmp_ok = 1'b0; host_wr_en = 1'b0; inval_all = 1'b0;
        check(wb_req == ewb, req, longint'(wb_req), longint'(ewb));
        if (ewb) check(wb_line == LW'(l), req, longint'(wb_line), longint'(l));
        if (ok && !hit) begin mv[l] = 1'b1; md[l] = 1'b0; end
        else mv[l] = 1'b0;
        if (hw) md[hl] = 1'b1;
        if (inv) for (int i = 0; i < NL; i++) mv[i] = 1'b0;
    endtask

    task automatic frame;
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        mcnt = (mcnt == 0) ? int'(static_reload) : mcnt - 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin md[i] = 0; mv[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(fetch_vld == 1'b0, "R1 fetch_vld", longint'(fetch_vld), 0);
        check(wb_req == 1'b0, "R1 wb_req", longint'(wb_req), 0);
        sweep("R1 reset sources");

        // R2: no request gives no answer
        tick();
        check(fetch_vld == 1'b0, "R2 idle", longint'(fetch_vld), 0);

        // R5 / R6: even lines succeed, odd lines fail
        for (int l = 0; l < NL; l++) compress(l, (l % 2) == 0, 1'b0, 0, 1'b0, "R5 R6 result");
        sweep("R3 valid clean");

        // R4: host writes at various offsets in lines
        hwrite(0, 0); hwrite(2, 5); hwrite(3, 7); hwrite(8, 2);
        sweep("R4 dirty sampled");

        // R6: failed compression on a dirty line keeps it dirty
        compress(8, 1'b0, 1'b0, 0, 1'b0, "R6 fail on dirty");
        compress(8, 1'b1, 1'b0, 0, 1'b0, "R5 recompress");
        hwrite(8, 1);
        sweep("R6 R4 after recompress");

        // R8 / R9: static frames
        static_reload = 3'd2;
        frame(); sweep("R9 static count 2");
        frame(); sweep("R9 static count 1");
        frame(); sweep("R8 sampling frame");
        frame(); sweep("R8 reload again");
        static_reload = 3'd0;
        frame(); frame(); sweep("R8 back to zero");
        frame(); sweep("R8 reload zero every frame");

        // R7: collision of host write and success on the same line
        compress(4, 1'b1, 1'b1, 4, 1'b0, "R7 collision");
        sweep("R7 line dirty not valid");
        // different line write during success is not a collision
        compress(10, 1'b1, 1'b1, 12, 1'b0, "R5 other line write");
        sweep("R5 R4 other line");

        // R10: global invalidate against a success
        compress(6, 1'b1, 1'b0, 0, 1'b1, "R10 inval vs success");
        sweep("R10 all invalid");
        compress(6, 1'b1, 1'b0, 0, 1'b0, "R5 after inval");
        sweep("R3 after inval");

        // R11: staging buffer
        for (int i = 0; i < SD; i++) begin
            stg_wr_en = 1'b1;
            stg_wr_idx = SIW'(i);
            stg_wr_data = SW'(32'h9E37_79B9 * (i + 1));
            tick();
        end
        stg_wr_en = 1'b0;
        for (int i = SD - 1; i >= 0; i--) begin
            stg_rd_idx = SIW'(i);
            tick();
            check(stg_rd_data == SW'(32'h9E37_79B9 * (i + 1)), "R11 staging read",
                  longint'(stg_rd_data), longint'(SW'(32'h9E37_79B9 * (i + 1))));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule